// File: doc/BRIEF.md
# Coprocessor Transfer Address Generator

This block produces the word addresses for a coprocessor memory transfer. A command carries a base register value, an unsigned offset counted in words, and flags that pick add or subtract, pre- or post-indexing, base writeback and a long/short transfer length hint. Once the command is accepted, the block issues one address per transfer beat on a valid/ready output. The first address depends on the indexing mode. Every later beat steps up by one word.

The block does not know how many beats there will be. The attached coprocessor ends the sequence by raising a last-beat flag on the beat it accepts as final. If writeback was requested, a single-cycle write-enable then appears, together with the updated base value. A command that arrives while a sequence is running is dropped. The busy output tells the issuing pipeline when a new command will be taken.

Top module: `cpxfer_addr_gen`

## Requirements
- R1: After reset, busy, addr_valid and wb_en are all 0.
- R2: The byte offset is the 8-bit word offset multiplied by 4. It is added to the base when cmd_up is 1 and subtracted when cmd_up is 0. All address arithmetic is 32-bit and wraps modulo 2^32.
- R3: With cmd_pre = 1 (pre-index), the first beat's address is the base with the byte offset applied.
- R4: With cmd_pre = 0 (post-index), the first beat's address is the unmodified base.
- R5: Each beat after the first carries the previous beat's address plus 4, whatever the direction flag.
- R6: While addr_valid is 1 and addr_ready is 0, addr and addr_long hold their values and addr_valid stays 1.
- R7: The sequence ends on the handshake (addr_valid and addr_ready both 1) where beat_last is 1, and addr_valid is 0 in the next cycle. Only beat_last sets the number of beats.
- R8: If cmd_wb was 1, wb_en is 1 for exactly one cycle, the cycle after the final handshake. In that cycle wb_value equals the base with the byte offset applied, in both indexing modes.
- R9: If cmd_wb was 0, wb_en stays 0 for the whole sequence.
- R10: A start asserted while busy is 1 has no effect on the addresses, addr_long or wb_value of the running sequence.
- R11: addr_long equals the cmd_long value of the accepted command during every beat.
- R12: busy is 1 from the cycle after an accepted start up to and including the writeback cycle. It is 0 in the cycle after the final handshake when no writeback was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe; taken only when idle |
| cmd_base | input | 32 | Base register value |
| cmd_offset | input | 8 | Unsigned offset in words |
| cmd_up | input | 1 | 1 adds the offset, 0 subtracts it |
| cmd_pre | input | 1 | 1 pre-index, 0 post-index |
| cmd_wb | input | 1 | 1 requests base writeback |
| cmd_long | input | 1 | Long/short transfer hint for the coprocessor |
| busy | output | 1 | A sequence or its writeback is in progress |
| addr_valid | output | 1 | addr holds a beat address |
| addr_ready | input | 1 | Coprocessor accepts the current beat |
| addr | output | 32 | Beat address |
| addr_long | output | 1 | Long/short hint of the running command |
| beat_last | input | 1 | Marks the accepted beat as final |
| wb_en | output | 1 | One-cycle base writeback strobe |
| wb_value | output | 32 | Updated base value |

## Verification
The hardest case to reach from the ports is a new command strobe that lands during a stalled beat, in the middle of a sequence with a different base. The dropped command is visible only as the absence of any change in the address stream and in the writeback value. To create it, the driver holds addr_ready low for chosen cycles from a stall mask and pulses start with a different command inside one of those stalls. The scoreboard then checks that the queued addresses still arrive unchanged and that wb_value matches the original command. Other runs place the base and offset so that both the offset subtraction and the per-beat increment cross the 32-bit boundary.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_WB   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cpx_offset_calc.sv
module cpx_offset_calc #(
  parameter int ADDR_W     = 32,
  parameter int OFFS_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offset,
  input  logic              up,
  input  logic              pre,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] moved_base
);
  localparam int SH  = $clog2(WORD_BYTES);
  localparam int PAD = ADDR_W - OFFS_W - SH;

  logic [ADDR_W-1:0] byte_off;

  generate
    if (SH > 0) begin : g_scaled
      assign byte_off = {{PAD{1'b0}}, offset, {SH{1'b0}}};
    end else begin : g_unscaled
      assign byte_off = {{PAD{1'b0}}, offset};
    end
  endgenerate

  always_comb begin
    moved_base = up ? (base + byte_off) : (base - byte_off);
    first_addr = pre ? moved_base : base;
  end
endmodule

// File: rtl/cpx_addr_stepper.sv
module cpx_addr_stepper #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (advance) begin
      addr <= addr + STEP;
    end
  end
endmodule

// File: rtl/cpx_seq_fsm.sv
module cpx_seq_fsm
  import cpx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wb_req,
  input  logic handshake,
  input  logic last,
  output logic load,
  output logic advance,
  output logic busy,
  output logic addr_valid,
  output logic wb_en
);
  seq_state_t state_q, state_d;
  logic       busy_d, valid_d, wben_d;

  assign load    = (state_q == SEQ_IDLE) && start;
  assign advance = (state_q == SEQ_RUN) && handshake && !last;

  always_comb begin
    state_d = state_q;
    busy_d  = busy;
    valid_d = addr_valid;
    wben_d  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          busy_d  = 1'b1;
          valid_d = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (handshake && last) begin
          valid_d = 1'b0;
          if (wb_req) begin
            state_d = SEQ_WB;
            wben_d  = 1'b1;
          end else begin
            state_d = SEQ_IDLE;
            busy_d  = 1'b0;
          end
        end
      end
      SEQ_WB: begin
        state_d = SEQ_IDLE;
        busy_d  = 1'b0;
      end
      default: begin
        state_d = SEQ_IDLE;
        busy_d  = 1'b0;
        valid_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      busy       <= 1'b0;
      addr_valid <= 1'b0;
      wb_en      <= 1'b0;
    end else begin
      state_q    <= state_d;
      busy       <= busy_d;
      addr_valid <= valid_d;
      wb_en      <= wben_d;
    end
  end
endmodule

// File: rtl/cpxfer_addr_gen.sv
module cpxfer_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int OFFS_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [OFFS_W-1:0] cmd_offset,
  input  logic              cmd_up,
  input  logic              cmd_pre,
  input  logic              cmd_wb,
  input  logic              cmd_long,
  output logic              busy,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_long,
  input  logic              beat_last,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  logic              load, advance, handshake;
  logic              wb_req_q;
  logic [ADDR_W-1:0] first_addr, moved_base;

  assign handshake = addr_valid && addr_ready;

  cpx_offset_calc #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WORD_BYTES(WORD_BYTES)
  ) calc_i (
    .base(cmd_base), .offset(cmd_offset), .up(cmd_up), .pre(cmd_pre),
    .first_addr(first_addr), .moved_base(moved_base)
  );

  cpx_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start), .wb_req(wb_req_q),
    .handshake(handshake), .last(beat_last),
    .load(load), .advance(advance), .busy(busy),
    .addr_valid(addr_valid), .wb_en(wb_en)
  );

  cpx_addr_stepper #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
  ) step_i (
    .clk(clk), .rst(rst), .load(load), .load_addr(first_addr),
    .advance(advance), .addr(addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_req_q  <= 1'b0;
      addr_long <= 1'b0;
      wb_value  <= '0;
    end else if (load) begin
      wb_req_q  <= cmd_wb;
      addr_long <= cmd_long;
      wb_value  <= moved_base;
    end
  end
endmodule

// File: rtl/cpxfer_addr_gen_chk.sv
module cpxfer_addr_gen_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_long,
  input logic              beat_last,
  input logic              wb_en,
  input logic [ADDR_W-1:0] wb_value
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr) && $stable(addr_long)); // R6
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    addr_valid && addr_ready && !beat_last |=> addr_valid && (addr == $past(addr) + STEP)); // R5
  AST_SEQ_END: assert property (@(posedge clk) disable iff (rst)
    addr_valid && addr_ready && beat_last |=> !addr_valid); // R7
  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en); // R8
  AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(addr_valid && addr_ready && beat_last)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !addr_valid && !wb_en); // R12
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(wb_value)); // R10
endmodule

bind cpxfer_addr_gen cpxfer_addr_gen_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .addr_valid(addr_valid),
  .addr_ready(addr_ready), .addr(addr), .addr_long(addr_long),
  .beat_last(beat_last), .wb_en(wb_en), .wb_value(wb_value)
);

// File: tb/cpxfer_addr_gen_tb_top.sv
module cpxfer_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [7:0]  cmd_offset = '0;
  logic        cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wb = 1'b0, cmd_long = 1'b0;
  logic        busy, addr_valid, addr_long, wb_en;
  logic        addr_ready = 1'b0, beat_last = 1'b0;
  logic [31:0] addr, wb_value;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  logic        exp_long = 1'b0;

  always #5 clk = ~clk;

  cpxfer_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_base(cmd_base),
    .cmd_offset(cmd_offset), .cmd_up(cmd_up), .cmd_pre(cmd_pre),
    .cmd_wb(cmd_wb), .cmd_long(cmd_long), .busy(busy),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr(addr),
    .addr_long(addr_long), .beat_last(beat_last), .wb_en(wb_en),
    .wb_value(wb_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: samples 3 ns after each falling edge, 2 ns before the rising edge
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!rst) begin
        if (prev_stall && addr_valid) check("R6 hold", addr, prev_addr);
        if (addr_valid && addr_ready) begin
          if (exp_q.size() == 0) check("R7 extra beat", 32'd1, 32'd0);
          else check("R3/R4/R5 beat address", addr, exp_q.pop_front());
          check("R11 long hint", {31'd0, addr_long}, {31'd0, exp_long});
        end
        prev_stall = addr_valid && !addr_ready;
        prev_addr  = addr;
      end
    end
  end

  // Driver: pushes expected addresses, runs the handshake, checks the end of sequence
  task automatic run_xfer(input logic [31:0] base, input logic [7:0] off,
                          input logic up, input logic pre, input logic w,
                          input logic lng, input int nbeats,
                          input logic [15:0] stall, input logic poke);
    logic [31:0] moved;
    logic [31:0] a;
    int i, k;
    logic poked;
    moved = up ? base + {22'd0, off, 2'b00} : base - {22'd0, off, 2'b00};
    a = pre ? moved : base;
    for (int j = 0; j < nbeats; j++) begin
      exp_q.push_back(a);
      a = a + 32'd4;
    end
    exp_long = lng;
    @(negedge clk);
    start = 1'b1; cmd_base = base; cmd_offset = off; cmd_up = up;
    cmd_pre = pre; cmd_wb = w; cmd_long = lng;
    @(negedge clk);
    start = 1'b0;
    cmd_base = ~base; cmd_offset = ~off; cmd_up = ~up; cmd_long = ~lng;
    #1 check("R12 busy after start", {31'd0, busy}, 32'd1);
    i = 0; k = 0; poked = 1'b0;
    while (i < nbeats) begin
      addr_ready = !stall[k % 16];
      beat_last  = addr_ready && (i == nbeats - 1);
      if (poke && !addr_ready && !poked) begin
        start = 1'b1; cmd_wb = ~w; cmd_pre = ~pre; poked = 1'b1;
      end else begin
        start = 1'b0;
      end
      k++;
      @(negedge clk);
      if (addr_ready) i++;
    end
    start = 1'b0; addr_ready = 1'b0; beat_last = 1'b0;
    #1;
    check("R7 valid low after last", {31'd0, addr_valid}, 32'd0);
    check(w ? "R8 wb pulse" : "R9 no wb", {31'd0, wb_en}, {31'd0, w});
    check("R12 busy in end cycle", {31'd0, busy}, {31'd0, w});
    if (w) begin
      check("R8 R10 wb value", wb_value, moved);
      @(negedge clk);
      #1;
      check("R8 single pulse", {31'd0, wb_en}, 32'd0);
      check("R12 idle after wb", {31'd0, busy}, 32'd0);
    end
    check("R7 all beats issued", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 valid", {31'd0, addr_valid}, 32'd0);
    check("R1 wb_en", {31'd0, wb_en}, 32'd0);
    // R3 R2: pre-index up, writeback
    run_xfer(32'h0000_1000, 8'd3, 1'b1, 1'b1, 1'b1, 1'b1, 3, 16'h0000, 1'b0);
    // R4 R10: post-index down, stalls and an ignored start
    run_xfer(32'h0000_2000, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0, 4, 16'h0005, 1'b1);
    // R2 R9: pre-index down wrapping below zero, no writeback
    run_xfer(32'h0000_0100, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, 2, 16'h0002, 1'b0);
    // R5: post-index up, beat increment wraps past 2^32
    run_xfer(32'hFFFF_FFF8, 8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3, 16'h0000, 1'b0);
    // R7: single beat, zero offset
    run_xfer(32'h0000_0040, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1, 16'h0003, 1'b0);
    // R8: post-index writeback wrapping upward
    run_xfer(32'hFFFF_FFFC, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 2, 16'h0001, 1'b1);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule